// File: doc/BRIEF.md
# Dual Gated 13-Bit Counter/Timer

This block holds two identical counter/timers, each with a 13-bit count split into a low byte (only its five least significant bits count) and a high byte. Each count advances on one of three sources. The first is the falling edge of a per-timer external count pin. The second is every system clock cycle. The third is a shared prescaled tick that divides the system clock by 12, 4 or 48. Counting happens only while the timer's run bit is set. If the timer's gate bit is also set, the timer's external gate pin must be high as well. This lets the timer measure how long a pulse stays high.

Software reaches the timers through a byte-wide register port. A write lands on the clock edge that samples `reg_we`. A read is combinational on `reg_addr`. The port has no handshake: every access completes in one cycle. When a count wraps from 0x1FFF to 0x0000, it sets a sticky overflow flag. The flag stays set until software writes it back to 0. The block has no streaming data path, so all pins are plain control and status signals.

Register map (`reg_addr`):
- 0, control: bit0 run timer 0, bit1 run timer 1, bit2 overflow flag timer 0, bit3 overflow flag timer 1.
- 1, mode: timer 0 uses bits 2:0 and timer 1 uses bits 6:4. Within each group, bit+0 is gate enable, bit+1 selects the external count pin, and bit+2 selects the system clock (1) or the prescaled tick (0).
- 2, scale: bits 1:0. 0 is divide-by-12, 1 is divide-by-4, 2 and 3 are divide-by-48.
- 3 and 4 are the low and high count bytes of timer 0. 5 and 6 are the low and high count bytes of timer 1. Address 7 reads 0.

Top module: `gt13_dual_timer`

## Requirements
- R1: After reset, every register reads 0 and both `ovf_flag` bits are 0.
- R2: With the pin-select bit (mode bit+1) at 1, the count advances by exactly one for each high-to-low transition of the timer's `cnt_pin`, and low-to-high transitions do not advance it. Each level must be held for at least one clock.
- R3: With pin-select 0 and clock bit (mode bit+2) 1, a running timer advances once per system clock cycle.
- R4: With pin-select 0 and clock bit 0, a running timer advances once every 12, 4 or 48 cycles for scale codes 0, 1 and 2. Scale code 3 also gives 48.
- R5: While the run bit is 0, the count does not change.
- R6: With the gate bit (mode bit+0) at 1, a running timer advances only while its `gate_pin` is high. With the gate bit at 0, `gate_pin` has no effect.
- R7: Setting the run bit leaves the previously loaded count unchanged.
- R8: The count is {high byte, low byte bits 4:0}. A carry out of low bit 4 increments the high byte. Low byte bits 7:5 read back as written and are never changed by counting.
- R9: A wrap from 0x1FFF to 0x0000 sets the timer's overflow flag (control bit 2 or 3, and `ovf_flag`). The flag stays set until a control write puts 0 in it. When a wrap and a control write land in the same cycle, the wrap wins.
- R10: Timer 1 behaves like timer 0, using its own run bit, mode bits, count pin, gate pin and flag. Activity on timer 1 does not change timer 0.
- R11: A write to either count byte of a timer takes priority over that timer's increment in the same cycle. The written value is held and no increment is applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pin | input | 2 | External count inputs, one per timer |
| gate_pin | input | 2 | External gate inputs, one per timer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ovf_flag | output | 2 | Sticky overflow flags, one per timer |

## Verification
The count is tried in four ways: the system clock, the prescaled tick at every scale code, a train of external pin pulses, and the system clock under gating with the gate pin held low and then high. Rates are measured as the count difference across a fixed window. A window of 48 cycles gives a distinct result for each divider, so a swapped scale decode is detected. Pulse trains with separate falling and rising phases show whether the design counts edges of the wrong polarity or counts an edge twice. Back-to-back control writes allow exactly one increment. That single step checks the carry from low bit 4, the protected upper low bits, and the 0x1FFF wrap together with a flag clear in the same cycle. Timer 1 runs while timer 0 is stopped, which checks that the two timers stay separate.

// File: rtl/gt13_pkg.sv
package gt13_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int MODE_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SCALE = 3'd2;
  localparam logic [ADDR_W-1:0] A_LO0   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI0   = 3'd4;
  localparam logic [ADDR_W-1:0] A_LO1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_HI1   = 3'd6;

  typedef struct packed {
    logic sys_clk;
    logic pin_sel;
    logic gate_en;
  } tmr_mode_t;
endpackage

// File: rtl/gt13_prescale.sv
module gt13_prescale #(
  parameter int DIV_A = 12,
  parameter int DIV_B = 4,
  parameter int DIV_C = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] scale,
  output logic       tick
);
  localparam int MAXD = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                        : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int PW = $clog2(MAXD);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    case (scale)
      2'd0:    lim = PW'(DIV_A - 1);
      2'd1:    lim = PW'(DIV_B - 1);
      default: lim = PW'(DIV_C - 1);
    endcase
  end

  assign tick = (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/gt13_edge_sync.sv
module gt13_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign fall = prev & ~sh[STAGES-1];

  // R2
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/gt13_core.sv
module gt13_core
  import gt13_pkg::*;
#(
  parameter int LO_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_t         mode,
  input  logic              run,
  input  logic              gate_lvl,
  input  logic              pin_fall,
  input  logic              pre_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_pulse
);
  localparam int CW = LO_BITS + BYTE_W;

  logic [CW-1:0] count;
  logic [CW-1:0] nxt;
  logic          src_tick;
  logic          enabled;
  logic          adv;

  assign count    = {hi_q, lo_q[LO_BITS-1:0]};
  assign nxt      = count + {{(CW-1){1'b0}}, 1'b1};
  assign src_tick = mode.pin_sel ? pin_fall : (mode.sys_clk ? 1'b1 : pre_tick);
  assign enabled  = run & (~mode.gate_en | gate_lvl);
  assign adv      = enabled & src_tick & ~wr_lo & ~wr_hi;
  assign ovf_pulse = adv & (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)    lo_q <= wdata;
      else if (adv) lo_q[LO_BITS-1:0] <= nxt[LO_BITS-1:0];
      if (wr_hi)    hi_q <= wdata;
      else if (adv) hi_q <= nxt[CW-1:LO_BITS];
    end
  end

  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> count == $past(count));
  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> count == CW'($past(count) + 1'b1));
  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> lo_q[BYTE_W-1:LO_BITS] == $past(lo_q[BYTE_W-1:LO_BITS]));
endmodule

// File: rtl/gt13_dual_timer.sv
module gt13_dual_timer
  import gt13_pkg::*;
#(
  parameter int LO_BITS     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 12,
  parameter int DIV_B       = 4,
  parameter int DIV_C       = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] cnt_pin,
  input  logic [NUM_TIMERS-1:0] gate_pin,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  output logic [NUM_TIMERS-1:0] ovf_flag
);
  logic [NUM_TIMERS-1:0] run_q;
  logic [NUM_TIMERS-1:0] flag_q;
  logic [BYTE_W-1:0]     mode_q;
  logic [1:0]            scale_q;
  logic                  pre_tick;
  logic [NUM_TIMERS-1:0] ovf_p;
  logic [BYTE_W-1:0]     lo_b [NUM_TIMERS];
  logic [BYTE_W-1:0]     hi_b [NUM_TIMERS];
  logic                  wr_ctrl;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

  gt13_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(rst_n), .scale(scale_q), .tick(pre_tick)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] ALO = ADDR_W'(3 + 2*i);
    localparam logic [ADDR_W-1:0] AHI = ADDR_W'(4 + 2*i);
    logic      cnt_lvl, cnt_fall, gate_lvl, gate_fall;
    tmr_mode_t m;

    assign m = tmr_mode_t'(mode_q[MODE_STRIDE*i +: 3]);

    gt13_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]), .lvl(cnt_lvl), .fall(cnt_fall)
    );
    gt13_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .pin(gate_pin[i]), .lvl(gate_lvl), .fall(gate_fall)
    );

    gt13_core #(.LO_BITS(LO_BITS)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(m), .run(run_q[i]),
      .gate_lvl(gate_lvl), .pin_fall(cnt_fall), .pre_tick(pre_tick),
      .wr_lo(reg_we && (reg_addr == ALO)), .wr_hi(reg_we && (reg_addr == AHI)),
      .wdata(reg_wdata), .lo_q(lo_b[i]), .hi_q(hi_b[i]), .ovf_pulse(ovf_p[i])
    );

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_p[i] |=> flag_q[i]);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !wr_ctrl) |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      flag_q  <= '0;
      mode_q  <= '0;
      scale_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= reg_wdata[NUM_TIMERS-1:0];
        flag_q <= reg_wdata[2*NUM_TIMERS-1:NUM_TIMERS] | ovf_p;
      end else begin
        flag_q <= flag_q | ovf_p;
      end
      if (reg_we && reg_addr == A_MODE)  mode_q  <= reg_wdata & 8'h77;
      if (reg_we && reg_addr == A_SCALE) scale_q <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0, flag_q, run_q};
      A_MODE:  reg_rdata = mode_q;
      A_SCALE: reg_rdata = {6'b0, scale_q};
      A_LO0:   reg_rdata = lo_b[0];
      A_HI0:   reg_rdata = hi_b[0];
      A_LO1:   reg_rdata = lo_b[1];
      A_HI1:   reg_rdata = hi_b[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R10
  t0_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(reg_we && (reg_addr == A_LO0 || reg_addr == A_HI0)))
      |=> (lo_b[0] == $past(lo_b[0]) && hi_b[0] == $past(hi_b[0])));
endmodule

// File: tb/tb_gt13_dual_timer.sv
module tb_gt13_dual_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gt13_dual_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic get_cnt(input int t, output int c);
    int lo, hi;
    rd(3'(3 + 2*t), lo);
    rd(3'(4 + 2*t), hi);
    c = (hi << 5) | (lo & 32'h1F);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg after reset", v, 0);
    end
    check("R1 ovf_flag after reset", int'(ovf_flag), 0);
  endtask

  task automatic t_sysclk;
    int c1, c2;
    wr(3'd1, 8'h04);
    wr(3'd3, 8'h0A);
    wr(3'd4, 8'h02);
    get_cnt(0, c1);
    check("R7 loaded count", c1, 32'h4A);
    wr(3'd0, 8'h01);
    get_cnt(0, c1);
    check("R7 count kept when run set", c1, 32'h4A);
    cyc(20);
    get_cnt(0, c2);
    check("R3 sysclk rate over 20 cycles", c2 - c1, 20);
  endtask

  task automatic t_run_off;
    int c1, c2;
    wr(3'd0, 8'h00);
    get_cnt(0, c1);
    cyc(10);
    get_cnt(0, c2);
    check("R5 stopped count stable", c2, c1);
  endtask

  task automatic t_prescale;
    int c1, c2;
    int expv [4] = '{4, 12, 1, 1};
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    for (int s = 0; s < 4; s++) begin
      wr(3'd2, 8'(s));
      cyc(50);
      get_cnt(0, c1);
      cyc(48);
      get_cnt(0, c2);
      check($sformatf("R4 prescale code %0d ticks in 48", s), c2 - c1, expv[s]);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_ext;
    int c1, c2, c3;
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h01);
    cnt_pin[0] = 1'b1;
    cyc(4);
    get_cnt(0, c1);
    for (int k = 0; k < 5; k++) begin
      cnt_pin[0] = 1'b0; cyc(3);
      cnt_pin[0] = 1'b1; cyc(3);
    end
    cyc(4);
    get_cnt(0, c2);
    check("R2 five falling edges", c2 - c1, 5);
    cnt_pin[0] = 1'b0; cyc(4);
    get_cnt(0, c3);
    check("R2 single falling edge", c3 - c2, 1);
    cnt_pin[0] = 1'b1; cyc(4);
    get_cnt(0, c2);
    check("R2 rising edge ignored", c2, c3);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_gate;
    int c1, c2;
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h01);
    gate_pin[0] = 1'b0; cyc(4);
    get_cnt(0, c1); cyc(10); get_cnt(0, c2);
    check("R6 gated low holds", c2 - c1, 0);
    gate_pin[0] = 1'b1; cyc(4);
    get_cnt(0, c1); cyc(10); get_cnt(0, c2);
    check("R6 gated high counts", c2 - c1, 10);
    gate_pin[0] = 1'b0;
    wr(3'd1, 8'h04);
    cyc(4);
    get_cnt(0, c1); cyc(10); get_cnt(0, c2);
    check("R6 gate pin ignored when gate bit 0", c2 - c1, 10);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_carry;
    int lo, hi;
    wr(3'd1, 8'h04);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h00);
    rd(3'd3, lo);
    check("R8 low byte readback", lo, 32'hFF);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd3, lo); rd(3'd4, hi);
    check("R8 low after carry keeps upper bits", lo, 32'hE0);
    check("R8 high after carry", hi, 32'h01);
  endtask

  task automatic t_roll;
    int c, v;
    wr(3'd1, 8'h04);
    wr(3'd3, 8'h1F);
    wr(3'd4, 8'hFF);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);
    get_cnt(0, c);
    check("R9 wrap to zero", c, 0);
    rd(3'd0, v);
    check("R9 flag set, wins over same-cycle clear", v, 32'h04);
    cyc(10);
    check("R9 flag sticky on port", int'(ovf_flag), 1);
    wr(3'd0, 8'h00);
    rd(3'd0, v);
    check("R9 flag cleared by write", v, 0);
  endtask

  task automatic t_wprio;
    int lo, hi;
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h01);
    cyc(3);
    wr(3'd3, 8'h05);
    rd(3'd3, lo);
    check("R11 low write beats increment", lo, 32'h05);
    wr(3'd4, 8'h33);
    rd(3'd3, lo); rd(3'd4, hi);
    check("R11 high write blocks increment (low)", lo, 32'h05);
    check("R11 high write value", hi, 32'h33);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_timer1;
    int a1, a2, b1, b2, v;
    wr(3'd1, 8'h50);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h02);
    gate_pin[1] = 1'b0; cyc(4);
    get_cnt(1, b1); cyc(10); get_cnt(1, b2);
    check("R10 timer1 gated low holds", b2 - b1, 0);
    gate_pin[1] = 1'b1; cyc(4);
    get_cnt(0, a1);
    get_cnt(1, b1); cyc(10); get_cnt(1, b2);
    get_cnt(0, a2);
    check("R10 timer1 counts with own gate", b2 - b1, 10);
    check("R10 timer0 untouched", a2, a1);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h1F);
    wr(3'd6, 8'hFF);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h00);
    rd(3'd0, v);
    check("R10 timer1 own overflow flag", v, 32'h08);
    check("R10 ovf_flag port", int'(ovf_flag), 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_sysclk();
    t_run_off();
    t_prescale();
    t_ext();
    t_gate();
    t_carry();
    t_roll();
    t_wprio();
    t_timer1();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule